// File: doc/BRIEF.md
# Complementary four-quadrant PWM generator

This block drives one active pair of half-bridges (leg A and leg B) with a complementary pattern. Two diagonal switch pairs take turns: pair X (leg A high side with leg B low side) and pair Y (leg A low side with leg B high side). Every clock belongs to one pair or the other, apart from the dead-time gaps. A mid-scale command splits the period evenly between the two pairs, so the motor sees a balanced bipolar current and holds torque at zero demand. The direction of torque follows from whether pair X gets more or less than half of the period. No direction bit is involved.

A triangle carrier counts up from zero to a programmable peak and back down again. It runs freely unless a rising edge on the synchronisation input restarts it early. The edge is accepted only when the period it cuts short would still be no more than 20 % faster than free-run. The signed duty command is offset binary and is clamped to a 5 %..95 % window. The command is sampled once per period. An active-low enable turns all four gates off. A synchronised overcurrent flag ends the on-time of the driving pair for the rest of the period.

A separate commutation decoder chooses which two bridge legs the outputs steer. This block only forms the pattern.

Top module: `comp_pwm_bridge`

## Requirements
- R1: With peak_i even, a mid-scale command (duty_i = 2048) and zero dead time, pair X is on for exactly peak_i clocks and pair Y for peak_i clocks of each period.
- R2: The carrier period is 2*peak_i clocks. With zero dead time, pair X is on for 2*floor(c*peak_i/4096) clocks per period, where c is the clamped command. Pair Y is on for the remaining clocks.
- R3: Before use, the command is clamped to the range 205..3891 (about 5 % and 95 % of full scale).
- R4: dir_o is 1 (counter-clockwise) when the clamped command sampled at the latest period start is below 2048, and 0 (clockwise) otherwise. The command is sampled at the clock in which the carrier count is zero.
- R5: a_hi_o and b_lo_o are always equal (pair X), as are a_lo_o and b_hi_o (pair Y). The two switches of one leg are never on together.
- R6: Every turn-on of a pair is delayed by dead_i clocks after any change of demanded pair, so each on-time shrinks by dead_i.
- R7: While en_ni is 1, all four gate outputs are 0 from the next clock on.
- R8: oc_i passes through two synchronising flops. The driving pair is X when dir_o is 0 and Y when dir_o is 1. A synchronised flag that arrives while the driving pair is demanded switches the driving pair off and the opposite pair on until the next period start. A flag that arrives while the opposite pair is demanded has no effect.
- R9: peak_o is a one-clock strobe at the carrier maximum, once per period.
- R10: A rising edge on sync_i (synchronised through two flops) restarts the carrier at count zero, but only if (e+1)*3 >= 5*peak_i, where e counts clocks since the period's zero-count clock. Otherwise the edge is ignored. A period therefore never exceeds 2*peak_i and never drops below 5/6 of it.
- R11: During reset, all gate outputs, peak_o and dir_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_ni | input | 1 | Output enable, active low |
| peak_i | input | 12 | Carrier peak count (even, at least 20) |
| duty_i | input | 12 | Offset-binary duty command, 2048 = zero |
| dead_i | input | 6 | Dead time in clocks |
| sync_i | input | 1 | External synchronisation square wave |
| oc_i | input | 1 | Overcurrent comparator flag |
| a_hi_o | output | 1 | Leg A high-side gate |
| a_lo_o | output | 1 | Leg A low-side gate |
| b_hi_o | output | 1 | Leg B high-side gate |
| b_lo_o | output | 1 | Leg B low-side gate |
| peak_o | output | 1 | Carrier-peak strobe |
| dir_o | output | 1 | Torque direction, 1 = counter-clockwise |

## Verification
The duty path is driven with:
- mid-scale commands and values just beside mid-scale, which separate an exact 50 % split from an off-by-one threshold and show the sign flip of dir_o;
- full-scale commands at both ends, which show whether the clamp acts;
- two carrier peaks and two dead times, which separate period scaling from on-time shrinkage.

The synchronisation input is exercised in three ways:
- a square wave slightly faster than free-run, which must lock;
- a much faster wave, which must be partly ignored;
- a slower wave, which must never stretch a period.

Overcurrent pulses are placed once inside the opposite pair's window, where they must be ignored, and once inside the driving pair's window, where they must cut it short.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  typedef enum logic [1:0] {
    DEM_NONE = 2'b00,
    DEM_X    = 2'b01,
    DEM_Y    = 2'b10
  } dem_e;
endpackage

// File: rtl/cpwm_sync.sv
module cpwm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '0;
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/cpwm_carrier.sv
module cpwm_carrier #(
  parameter int CW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] peak_i,
  input  logic          restart_i,
  output logic [CW-1:0] cnt_o,
  output logic          up_o,
  output logic          start_o,
  output logic          peak_o
);
  localparam int AW = CW + 1;
  localparam int XW = CW + 3;

  logic [CW-1:0] cnt_q;
  logic          up_q;
  logic [AW-1:0] age_q;
  logic [XW-1:0] age_x3, min_x5;
  logic          accept;

  // restart only if the shortened period keeps frequency within +20 %
  assign age_x3 = ({2'b00, age_q} + XW'(1)) * XW'(3);
  assign min_x5 = {3'b000, peak_i} * XW'(5);
  assign accept = restart_i && (age_x3 >= min_x5);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
      age_q <= '0;
    end else if (accept) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
      age_q <= '0;
    end else if (up_q) begin
      age_q <= age_q + AW'(1);
      if (cnt_q >= peak_i) begin
        up_q  <= 1'b0;
        cnt_q <= cnt_q - CW'(1);
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end else if (cnt_q <= CW'(1)) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
      age_q <= '0;
    end else begin
      cnt_q <= cnt_q - CW'(1);
      age_q <= age_q + AW'(1);
    end
  end

  assign cnt_o   = cnt_q;
  assign up_o    = up_q;
  assign start_o = (cnt_q == '0);
  assign peak_o  = up_q && (cnt_q >= peak_i);
endmodule

// File: rtl/cpwm_duty.sv
module cpwm_duty #(
  parameter int CW      = 12,
  parameter int MIN_PCT = 5,
  parameter int MAX_PCT = 95
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [CW-1:0] duty_i,
  input  logic [CW-1:0] peak_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          up_i,
  output logic          x_dem_o,
  output logic          dir_o
);
  localparam int            FS  = 1 << CW;
  localparam logic [CW-1:0] MID = CW'(FS / 2);
  localparam logic [CW-1:0] LO  = CW'((FS * MIN_PCT + 50) / 100);
  localparam logic [CW-1:0] HI  = CW'((FS * MAX_PCT) / 100);

  logic [CW-1:0]   clamped, dq_q, thr;
  logic [2*CW-1:0] prod;

  always_comb begin
    clamped = duty_i;
    if (duty_i < LO) clamped = LO;
    if (duty_i > HI) clamped = HI;
  end

  // command is held for a whole carrier period
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      dq_q <= MID;
    else if (start_i) dq_q <= clamped;
  end

  assign prod = dq_q * peak_i;
  assign thr  = CW'(prod >> CW);

  // window centred on count zero, 2*thr clocks wide
  assign x_dem_o = (cnt_i < thr) || (!up_i && (cnt_i == thr));
  assign dir_o   = (dq_q < MID);
endmodule

// File: rtl/cpwm_gate.sv
module cpwm_gate
  import cpwm_pkg::*;
#(
  parameter int DTW = 6
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  dem_e           dem_i,
  input  logic [DTW-1:0] dead_i,
  output logic           x_o,
  output logic           y_o
);
  dem_e           dem_q;
  logic [DTW-1:0] age_q, age_d;
  logic           chg, ok;

  assign chg = (dem_i != dem_q);

  always_comb begin
    if (chg)               age_d = '0;
    else if (age_q == '1)  age_d = age_q;
    else                   age_d = age_q + DTW'(1);
  end

  assign ok = (age_d >= dead_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dem_q <= DEM_NONE;
      age_q <= '1;
      x_o   <= 1'b0;
      y_o   <= 1'b0;
    end else begin
      dem_q <= dem_i;
      age_q <= age_d;
      x_o   <= (dem_i == DEM_X) && ok;
      y_o   <= (dem_i == DEM_Y) && ok;
    end
  end
endmodule

// File: rtl/comp_pwm_bridge.sv
module comp_pwm_bridge
  import cpwm_pkg::*;
#(
  parameter int CW      = 12,
  parameter int DTW     = 6,
  parameter int SYNC_FF = 2,
  parameter int MIN_PCT = 5,
  parameter int MAX_PCT = 95
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_ni,
  input  logic [CW-1:0]  peak_i,
  input  logic [CW-1:0]  duty_i,
  input  logic [DTW-1:0] dead_i,
  input  logic           sync_i,
  input  logic           oc_i,
  output logic           a_hi_o,
  output logic           a_lo_o,
  output logic           b_hi_o,
  output logic           b_lo_o,
  output logic           peak_o,
  output logic           dir_o
);
  logic [CW-1:0] cnt;
  logic          up, start, x_dem, dir;
  logic          sync_s, sync_d_q, sync_rise;
  logic          oc_s, trip_q, drv_x, drv_dem;
  logic          x_on, y_on;
  dem_e          dem;

  cpwm_sync #(.STAGES(SYNC_FF)) u_sync_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(sync_i), .q_o(sync_s)
  );

  cpwm_sync #(.STAGES(SYNC_FF)) u_oc_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(oc_i), .q_o(oc_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_d_q <= 1'b0;
    else         sync_d_q <= sync_s;
  end

  assign sync_rise = sync_s && !sync_d_q;

  cpwm_carrier #(.CW(CW)) u_carrier (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .peak_i   (peak_i),
    .restart_i(sync_rise),
    .cnt_o    (cnt),
    .up_o     (up),
    .start_o  (start),
    .peak_o   (peak_o)
  );

  cpwm_duty #(.CW(CW), .MIN_PCT(MIN_PCT), .MAX_PCT(MAX_PCT)) u_duty (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .duty_i (duty_i),
    .peak_i (peak_i),
    .cnt_i  (cnt),
    .up_i   (up),
    .x_dem_o(x_dem),
    .dir_o  (dir)
  );

  // driving pair follows the sign of the command
  assign drv_x   = !dir;
  assign drv_dem = drv_x ? x_dem : !x_dem;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trip_q <= 1'b0;
    else         trip_q <= (trip_q && !start) || (oc_s && drv_dem && !en_ni);
  end

  always_comb begin
    dem = DEM_NONE;
    if (!en_ni) begin
      if (trip_q)     dem = drv_x ? DEM_Y : DEM_X;
      else if (x_dem) dem = DEM_X;
      else            dem = DEM_Y;
    end
  end

  cpwm_gate #(.DTW(DTW)) u_gate (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .dem_i (dem),
    .dead_i(dead_i),
    .x_o   (x_on),
    .y_o   (y_on)
  );

  assign a_hi_o = x_on;
  assign b_lo_o = x_on;
  assign a_lo_o = y_on;
  assign b_hi_o = y_on;
  assign dir_o  = dir;
endmodule

// File: rtl/cpwm_chk.sv
module cpwm_chk #(
  parameter int DTW = 6
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           en_ni,
  input logic [DTW-1:0] dead_i,
  input logic           a_hi_o,
  input logic           a_lo_o,
  input logic           b_hi_o,
  input logic           b_lo_o,
  input logic           peak_o
);
  AST_LEG_A_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(a_hi_o && a_lo_o)); // R5
  AST_LEG_B_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(b_hi_o && b_lo_o)); // R5
  AST_DIAG_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_hi_o == b_lo_o) && (a_lo_o == b_hi_o)); // R5
  AST_DISABLE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_ni |=> !(a_hi_o || a_lo_o || b_hi_o || b_lo_o)); // R7
  AST_DEAD_X_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dead_i != '0) && $rose(a_hi_o) |-> !$past(a_lo_o)); // R6
  AST_DEAD_Y_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dead_i != '0) && $rose(a_lo_o) |-> !$past(a_hi_o)); // R6
  AST_PEAK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    peak_o |=> !peak_o); // R9
endmodule

bind comp_pwm_bridge cpwm_chk #(.DTW(DTW)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .en_ni (en_ni),
  .dead_i(dead_i),
  .a_hi_o(a_hi_o),
  .a_lo_o(a_lo_o),
  .b_hi_o(b_hi_o),
  .b_lo_o(b_lo_o),
  .peak_o(peak_o)
);

// File: tb/comp_pwm_bridge_tb_top.sv
module comp_pwm_bridge_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni, en_ni, sync_i, oc_i;
  logic [11:0] peak_i, duty_i;
  logic [5:0]  dead_i;
  logic        a_hi_o, a_lo_o, b_hi_o, b_lo_o, peak_o, dir_o;

  int n_chk = 0;
  int n_err = 0;
  int sync_half = 0;

  typedef struct packed {
    int peak; int duty; int dead; int xon; int yon; int dir;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{100, 2048, 0, 100, 100, 0},  // R1 zero command
    '{100, 3072, 0, 150,  50, 0},  // R2
    '{100, 1024, 0,  50, 150, 1},  // R2 R4
    '{100, 4095, 0, 188,  12, 0},  // R3 upper clamp
    '{100,    0, 0,  10, 190, 1},  // R3 lower clamp, R4
    '{100, 2048, 7,  93,  93, 0},  // R6
    '{ 64, 2048, 0,  64,  64, 0},  // R1 other peak
    '{ 64, 2560, 0,  80,  48, 0},  // R2
    '{100, 2047, 0,  98, 102, 1},  // R4 just below mid
    '{100, 3000, 3, 143,  51, 0}   // R6
  };

  comp_pwm_bridge dut_i (
    .clk_i (clk_i), .rst_ni(rst_ni), .en_ni(en_ni), .peak_i(peak_i),
    .duty_i(duty_i), .dead_i(dead_i), .sync_i(sync_i), .oc_i(oc_i),
    .a_hi_o(a_hi_o), .a_lo_o(a_lo_o), .b_hi_o(b_hi_o), .b_lo_o(b_lo_o),
    .peak_o(peak_o), .dir_o(dir_o)
  );

  always #4 clk_i = ~clk_i;

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  endtask

  task automatic check(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic wait_peak();
    do @(negedge clk_i); while (!peak_o);
  endtask

  task automatic next_interval(output int n);
    n = 0;
    do begin @(negedge clk_i); n++; end while (!peak_o);
  endtask

  task automatic measure(int cycles, output int xa, output int ya,
                         output int xb, output int yb);
    xa = 0; ya = 0; xb = 0; yb = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk_i);
      if (a_hi_o) xa++;
      if (a_lo_o) ya++;
      if (b_lo_o) xb++;
      if (b_hi_o) yb++;
    end
  endtask

  initial begin
    sync_i = 1'b0;
    forever begin
      if (sync_half == 0) begin
        sync_i = 1'b0;
        @(negedge clk_i);
      end else begin
        repeat (sync_half) @(negedge clk_i);
        sync_i = ~sync_i;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int xa, ya, xb, yb, n, mn, mx;
    rst_ni = 1'b0; en_ni = 1'b0; peak_i = 12'd100; duty_i = 12'd2048;
    dead_i = 6'd0; oc_i = 1'b0;
    repeat (3) @(negedge clk_i);
    check("R11 gates in reset", int'({a_hi_o, a_lo_o, b_hi_o, b_lo_o}), 0);
    check("R11 peak_o in reset", int'(peak_o), 0);
    check("R11 dir_o in reset", int'(dir_o), 0);
    rst_ni = 1'b1;

    for (int v = 0; v < NV; v++) begin
      en_ni = 1'b1;
      @(negedge clk_i);
      peak_i = 12'(VECS[v].peak);
      duty_i = 12'(VECS[v].duty);
      dead_i = 6'(VECS[v].dead);
      repeat (4) @(negedge clk_i);
      en_ni = 1'b0;
      repeat (3) wait_peak();
      measure(2 * VECS[v].peak, xa, ya, xb, yb);
      check($sformatf("R1/R2 pair X on-time v%0d", v), xa, VECS[v].xon);
      check($sformatf("R2 pair Y on-time v%0d", v), ya, VECS[v].yon);
      check($sformatf("R5 b_lo tracks a_hi v%0d", v), xb, xa);
      check($sformatf("R5 b_hi tracks a_lo v%0d", v), yb, ya);
      check($sformatf("R4 dir_o v%0d", v), int'(dir_o), VECS[v].dir);
    end

    // R9 free-run period and single strobe
    peak_i = 12'd100; duty_i = 12'd2048; dead_i = 6'd0;
    repeat (2) wait_peak();
    next_interval(n);
    check("R9 free-run peak interval P=100", n, 200);
    peak_i = 12'd64;
    repeat (2) wait_peak();
    next_interval(n);
    check("R9 free-run peak interval P=64", n, 128);
    peak_i = 12'd100;
    repeat (2) wait_peak();

    // R7 disable
    en_ni = 1'b1;
    @(negedge clk_i);
    check("R7 gates off after disable",
          int'({a_hi_o, a_lo_o, b_hi_o, b_lo_o}), 0);
    measure(200, xa, ya, xb, yb);
    check("R7 no gate activity while disabled", xa + ya + xb + yb, 0);
    en_ni = 1'b0;

    // R8 overcurrent, Y drives (command below mid)
    duty_i = 12'd1024;
    repeat (3) wait_peak();
    wait_peak();
    repeat (85) @(negedge clk_i);
    oc_i = 1'b1;
    repeat (3) @(negedge clk_i);
    oc_i = 1'b0;
    wait_peak();
    measure(200, xa, ya, xb, yb);
    check("R8 flag in opposite window ignored", ya, 150);

    wait_peak();
    fork
      measure(200, xa, ya, xb, yb);
      begin
        repeat (20) @(negedge clk_i);
        oc_i = 1'b1;
        repeat (2) @(negedge clk_i);
        oc_i = 1'b0;
      end
    join
    check("R8 driving pair cut short", int'(ya < 150), 1);
    check("R8 opposite pair fills cut", xa + ya, 200);
    wait_peak();
    measure(200, xa, ya, xb, yb);
    check("R8 normal on-time next period", ya, 150);

    // R10 synchronisation
    duty_i = 12'd2048;
    sync_half = 90;
    wait_peak();
    repeat (12) next_interval(n);
    for (int i = 0; i < 4; i++) begin
      next_interval(n);
      check("R10 locked to 180-clock sync", n, 180);
    end

    sync_half = 60;
    wait_peak();
    repeat (2) next_interval(n);
    mn = 100000; mx = 0;
    for (int i = 0; i < 10; i++) begin
      next_interval(n);
      if (n < mn) mn = n;
      if (n > mx) mx = n;
    end
    check("R10 fast sync min period", int'(mn >= 167), 1);
    check("R10 fast sync max period", int'(mx <= 200), 1);

    sync_half = 130;
    wait_peak();
    repeat (2) next_interval(n);
    mn = 100000; mx = 0;
    for (int i = 0; i < 10; i++) begin
      next_interval(n);
      if (n < mn) mn = n;
      if (n > mx) mx = n;
    end
    check("R10 slow sync never stretches", int'(mx <= 200), 1);
    check("R10 slow sync min period", int'(mn >= 167), 1);
    sync_half = 0;

    finish_run();
  end
endmodule